// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 64 pins, organised as two banks of 32. Each pin has an output-enable bit and an output latch. The latch is never written directly. Software raises bits through a write-one-to-set word and lowers them through a write-one-to-clear word. This gives atomic per-pin updates with no read-modify-write. Pin inputs pass through a two-flop synchronizer, and their synchronized state can be read back.

Rising and falling edge detection can be enabled independently for each pin. A detected edge latches a sticky status bit that software clears by writing ones. Writing back the value just read therefore acknowledges exactly the edges that were seen. One interrupt output is high while any status bit is set.

The register bus takes one access per cycle. Writes take effect at the clock edge where the write enable is sampled high. Read data is registered, so it appears one cycle after the read enable and then holds.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe_o all zero), every output latch is low, all edge enables and status bits are zero, irq_o is low and rdata_o is zero.
- R2: Pin n belongs to bank n/32 at bit n%32. Within each two-word group, byte offset +0 addresses bank 0 (pins 0 to 31) and +4 addresses bank 1 (pins 32 to 63).
- R3: The direction words sit at 0x08 and 0x0C. A 1 makes the pin's pin_oe_o bit high (output) and a 0 makes it low (input). The word reads back as written.
- R4: The set words (0x10, 0x14) and the clear words (0x18, 0x1C) act on the output latch, which drives pin_o. A 1 in a set write raises the latch. A 1 in a clear write lowers it. A 0 bit in either leaves the latch unchanged.
- R5: The set and clear words read as zero.
- R6: The level words (0x00, 0x04) return pin_i after a two-flop synchronizer. Writes to them have no effect.
- R7: The rising-enable words (0x20, 0x24) and falling-enable words (0x28, 0x2C) are independent per pin. An enabled edge sets the pin's status bit, and a pin with both enables set detects either edge. A transition whose direction is not enabled sets nothing.
- R8: The status words (0x30, 0x34) are sticky. A status bit stays set until a write puts a 1 in that bit position, and a 0 bit in such a write leaves it unchanged.
- R9: irq_o is high exactly while at least one status bit in either bank is set, beginning the cycle after the bit is latched.
- R10: When a newly detected edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: rdata_o loads at the clock edge where re_i is high and holds otherwise. A read of an address with addr_i[1:0] not zero, or of the unused group at 0x38/0x3C, returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the register access |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 64 | Pin input levels |
| pin_o | output | 64 | Output latch values |
| pin_oe_o | output | 64 | Output enables (1 = output) |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The bench aims at the collision of a new edge with a clearing write on the same status bit. A design that lets the clear win would drop an edge, and the bit would read zero. It checks that writing zero bits to the status and latch words touches nothing, and that a design decoding the write data as a plain store would visibly wipe other pins. Per-pin edge selection is exercised with only one direction enabled, where a design that detects any change would set a bit that must stay clear. Bank selection is exercised with patterns that differ between the two words, so swapped or aliased banks show up on pin_oe_o, pin_o and the status reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DIR   = 3'd1,
    GRP_SET   = 3'd2,
    GRP_CLR   = 3'd3,
    GRP_RISE  = 3'd4,
    GRP_FALL  = 3'd5,
    GRP_STAT  = 3'd6,
    GRP_NONE  = 3'd7
  } grp_e;

  typedef struct packed {
    logic wr;
    grp_e grp;
  } bank_cmd_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, hit;

  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      hit[i] = (rise_en_i[i] & lvl_i[i] & ~prev_i[i]) |
               (fall_en_i[i] & ~lvl_i[i] & prev_i[i]);
    end
  end

  // new edge dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  bank_cmd_t    cmd_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q;
  logic [W-1:0] lvl, prev, clr, stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (cmd_i.wr) begin
      case (cmd_i.grp)
        GRP_DIR:  dir_q  <= wdata_i;
        GRP_RISE: rise_q <= wdata_i;
        GRP_FALL: fall_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else if (cmd_i.wr && cmd_i.grp == GRP_SET) begin
      out_q <= out_q | wdata_i;
    end else if (cmd_i.wr && cmd_i.grp == GRP_CLR) begin
      out_q <= out_q & ~wdata_i;
    end
  end

  assign clr = (cmd_i.wr && cmd_i.grp == GRP_STAT) ? wdata_i : '0;

  gpio_sync #(.W(W)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  gpio_edge #(.W(W)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .prev_i    (prev),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .clr_i     (clr),
    .stat_o    (stat)
  );

  always_comb begin
    case (cmd_i.grp)
      GRP_LEVEL: rdata_o = lvl;
      GRP_DIR:   rdata_o = dir_q;
      GRP_RISE:  rdata_o = rise_q;
      GRP_FALL:  rdata_o = fall_q;
      GRP_STAT:  rdata_o = stat;
      default:   rdata_o = '0;
    endcase
  end

  assign pin_o  = out_q;
  assign oe_o   = dir_q;
  assign stat_o = stat;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 64,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W,
  localparam int unsigned BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W    = BSEL_W + 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BANK_W-1:0]   wdata_i,
  input  logic                re_i,
  output logic [BANK_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic              aligned;
  logic [BSEL_W-1:0] bank_sel;
  grp_e              grp;
  logic [NUM_PINS-1:0] edge_stat;
  logic [BANK_W-1:0] bank_rdata [NUM_BANKS];
  logic [BANK_W-1:0] rdata_q, rdata_d;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign bank_sel = addr_i[BSEL_W+1:2];
  assign grp      = grp_e'(addr_i[ADDR_W-1:ADDR_W-3]);

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    bank_cmd_t cmd;
    always_comb begin
      cmd.grp = grp;
      cmd.wr  = we_i && aligned && (bank_sel == BSEL_W'(b));
    end

    gpio_bank #(.W(BANK_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_i   (cmd),
      .wdata_i (wdata_i),
      .pin_i   (pin_i[b*BANK_W +: BANK_W]),
      .pin_o   (pin_o[b*BANK_W +: BANK_W]),
      .oe_o    (pin_oe_o[b*BANK_W +: BANK_W]),
      .stat_o  (edge_stat[b*BANK_W +: BANK_W]),
      .rdata_o (bank_rdata[b])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (aligned && bank_sel == BSEL_W'(b)) rdata_d = bank_rdata[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |edge_stat;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned BANK_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic                re_i,
  input logic [BANK_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] stat_i
);
  logic [2:0] g;
  logic       al;
  assign g  = addr_i[ADDR_W-1:ADDR_W-3];
  assign al = (addr_i[1:0] == 2'b00);

  assert_oe_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_o) |-> $past(we_i && al && g == 3'd1));

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> $past(we_i && al && (g == 3'd2 || g == 3'd3)));

  assert_wo_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i && al && (g == 3'd2 || g == 3'd3)) |-> (rdata_o == '0));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && al && g == 3'd6) |-> ((stat_i & $past(stat_i)) == $past(stat_i)));

  assert_irq_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(we_i && al && g == 3'd6));

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(re_i) |-> $stable(rdata_o));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_PINS (NUM_PINS),
  .BANK_W   (BANK_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .stat_i   (edge_stat)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .we_i     (we),
    .wdata_i  (wdata),
    .re_i     (re),
    .rdata_o  (rdata),
    .pin_i    (pin_in),
    .pin_o    (pin_out),
    .pin_oe_o (pin_oe),
    .irq_o    (irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // behavioural reference model
  logic [63:0] m_dir, m_out, m_rise, m_fall, m_stat;
  logic [31:0] m_rdata;
  logic [63:0] hist[$];
  logic [63:0] s_cur, s_old, hit, clr;

  function automatic logic [31:0] model_read(input int g, input int b);
    logic [63:0] v;
    case (g)
      0: v = s_cur;
      1: v = m_dir;
      4: v = m_rise;
      5: v = m_fall;
      6: v = m_stat;
      default: v = '0;
    endcase
    return v[b*32 +: 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0; m_rdata = '0;
      hist = {};
      for (int i = 0; i < 3; i++) hist.push_back(64'd0);
    end else begin
      int g, b;
      bit al;
      s_cur = hist[1];
      s_old = hist[2];
      g  = int'(addr[5:3]);
      b  = int'(addr[2]);
      al = (addr[1:0] == 2'b00);
      hit = (s_cur & ~s_old & m_rise) | (~s_cur & s_old & m_fall);
      if (re) m_rdata = al ? model_read(g, b) : 32'd0;
      clr = '0;
      if (we && al) begin
        case (g)
          1: m_dir[b*32 +: 32] = wdata;
          2: m_out[b*32 +: 32] = m_out[b*32 +: 32] | wdata;
          3: m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~wdata;
          4: m_rise[b*32 +: 32] = wdata;
          5: m_fall[b*32 +: 32] = wdata;
          6: clr[b*32 +: 32] = wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | hit;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 rdata vs model", {32'd0, rdata}, {32'd0, m_rdata});
      chk("R4 pin_o vs model", pin_out, m_out);
      chk("R3 pin_oe_o vs model", pin_oe, m_dir);
      chk("R9 irq vs model", {63'd0, irq}, {63'd0, (m_stat != 0)});
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(2);
    // R1 during reset
    chk("R1 oe in reset", pin_oe, 64'd0);
    chk("R1 pin_o in reset", pin_out, 64'd0);
    chk("R1 irq in reset", {63'd0, irq}, 64'd0);
    chk("R1 rdata in reset", {32'd0, rdata}, 64'd0);
    rst_n = 1'b1;
    idle(1);
    for (int a = 8; a < 56; a += 4) begin
      rd(a[5:0], d);
      chk("R1 register zero after reset", {32'd0, d}, 64'd0);
    end

    // R3 / R2 direction
    wr(6'h08, 32'h0000_00F0);
    wr(6'h0C, 32'h8000_0001);
    chk("R3 R2 oe after direction writes", pin_oe, 64'h8000_0001_0000_00F0);
    rd(6'h0C, d);
    chk("R3 direction readback bank1", {32'd0, d}, 64'h8000_0001);
    // R11 misaligned write ignored
    wr(6'h09, 32'hFFFF_FFFF);
    chk("R11 misaligned write ignored", pin_oe, 64'h8000_0001_0000_00F0);
    rd(6'h09, d);
    chk("R11 misaligned read zero", {32'd0, d}, 64'd0);
    rd(6'h38, d);
    chk("R11 unused group reads zero", {32'd0, d}, 64'd0);

    // R4 set/clear
    wr(6'h10, 32'h0000_0031);
    wr(6'h14, 32'h8000_0000);
    chk("R4 R2 set", pin_out, 64'h8000_0000_0000_0031);
    wr(6'h18, 32'h0000_0001);
    chk("R4 clear one bit", pin_out, 64'h8000_0000_0000_0030);
    wr(6'h10, 32'h0000_0000);
    wr(6'h1C, 32'h0000_0000);
    chk("R4 zero bits unchanged", pin_out, 64'h8000_0000_0000_0030);
    rd(6'h10, d);
    chk("R5 set reads zero", {32'd0, d}, 64'd0);
    rd(6'h1C, d);
    chk("R5 clear reads zero", {32'd0, d}, 64'd0);

    // R6 level
    pin_in = 64'hA5A5_0000_0000_1234;
    idle(3);
    rd(6'h00, d);
    chk("R6 level bank0", {32'd0, d}, 64'h1234);
    rd(6'h04, d);
    chk("R6 R2 level bank1", {32'd0, d}, 64'hA5A5_0000);
    idle(2);
    chk("R11 rdata holds without read", {32'd0, rdata}, 64'hA5A5_0000);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d);
    chk("R6 level write ignored", {32'd0, d}, 64'h1234);
    chk("R8 no edges while disabled", {63'd0, irq}, 64'd0);

    // R7 edges
    pin_in = '0;
    idle(4);
    wr(6'h20, 32'h1);
    wr(6'h28, 32'h2);
    wr(6'h24, 32'h8);
    wr(6'h2C, 32'h8);
    pin_in = 64'h0000_0008_0000_0003;
    idle(4);
    rd(6'h30, d);
    chk("R7 rising only bit0", {32'd0, d}, 64'h1);
    rd(6'h34, d);
    chk("R7 R2 pin35 rising", {32'd0, d}, 64'h8);
    chk("R9 irq set", {63'd0, irq}, 64'd1);
    wr(6'h34, 32'h8);
    rd(6'h34, d);
    chk("R8 clear bank1", {32'd0, d}, 64'd0);
    chk("R9 irq from bank0 alone", {63'd0, irq}, 64'd1);
    pin_in = '0;
    idle(4);
    rd(6'h30, d);
    chk("R7 falling bit1", {32'd0, d}, 64'h3);
    rd(6'h34, d);
    chk("R7 pin35 either edge", {32'd0, d}, 64'h8);
    wr(6'h30, 32'h0);
    rd(6'h30, d);
    chk("R8 zero write keeps status", {32'd0, d}, 64'h3);
    wr(6'h34, 32'h8);
    wr(6'h30, 32'h3);
    chk("R9 irq low after clears", {63'd0, irq}, 64'd0);

    // R10 collision
    pin_in[0] = 1'b1;
    idle(4);
    pin_in[0] = 1'b0;
    idle(4);
    rd(6'h30, d);
    chk("R7 bit0 set, no falling enable", {32'd0, d}, 64'h1);
    pin_in[0] = 1'b1;
    idle(2);
    wr(6'h30, 32'h1);
    rd(6'h30, d);
    chk("R10 edge wins over clear", {32'd0, d}, 64'h1);
    wr(6'h30, 32'h1);
    rd(6'h30, d);
    chk("R8 clear after collision", {32'd0, d}, 64'd0);
    chk("R9 irq low at end", {63'd0, irq}, 64'd0);

    idle(2);
    summary();
    $finish;
  end
endmodule